// File: doc/BRIEF.md
# Masked-Write PHY Configuration Register Bank

This block is a small memory-mapped bank of control registers that drives the static configuration of a multi-lane serial display transmitter PHY. A bus master reaches it through a simple two-phase peripheral port with a setup cycle and an access cycle. Every 32-bit write carries its own per-bit write enable: the upper half of the write word decides which bits of the lower half may change. Software can therefore flip a single lane's power-down or idle bit without reading the register first.

The bank holds twelve 16-bit control words at byte offsets 0x00 to 0x2C. All of them appear on a flat configuration bus. The fields the PHY uses most (lane power and idle, PLL dividers, spread-spectrum settings, auxiliary channel power) are also decoded onto named outputs. A read-only status word at 0x30 reports the PLL-ready input. The word at 0x34 is a status slot with no flags and reads as zero. Reset is synchronous and active low. It leaves the lanes, the PLL and the auxiliary channel powered down and idle.

Top module: `phy_cfg_regbank`

## Requirements
- R1: A write sets stored bit i (0..15) of the addressed control word to write-data bit i only when write-data bit i+16 is 1. Where that mask bit is 0, the stored bit keeps its old value.
- R2: A read of a control word returns the stored 16-bit value in bits 15:0 and zeros in bits 31:16. Read data is valid in the same cycle as the read request (psel high, pwrite low).
- R3: After reset, the word at 0x00 reads 0x0FF1 and the word at 0x28 reads 0x0007. Every other control word reads 0x0000.
- R4: A read of offset 0x30 returns the pll_ready input in bit 0 and zeros elsewhere. A read of offset 0x34 returns zero.
- R5: Writes to 0x30, 0x34 or any offset above them change no stored word. Reads of offsets above 0x34 return zero.
- R6: The word at 0x00 drives lane_idle from bits 11:8, lane_pd from bits 7:4 (bit 4+n for lane n), iddq_en from bit 1 and pll_pd from bit 0.
- R7: The word at 0x04 drives pll_fbdiv from bits 14:0. The word at 0x08 drives tx_term from bits 10:8, rate_sel from bits 5:4 and ref_div from bits 3:0.
- R8: The word at 0x18 drives ssc_depth from bits 15:12, ssc_en from bit 11 and ssc_cnt from bits 9:0.
- R9: The word at 0x28 drives aux_idle from bit 2, aux_rx_pd from bit 1 and aux_tx_pd from bit 0. phy_up is high exactly when bit 2 is 0.
- R10: A write takes effect only in the access cycle, when psel, penable and pwrite are all high. Its result appears on the outputs in the cycle after that clock edge. A setup cycle on its own changes nothing.
- R11: An offset whose two low bits are not zero selects no register. Writes to it are ignored and reads of it return zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| psel | input | 1 | Bank selected |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset |
| pwdata | input | 32 | Write mask [31:16], write data [15:0] |
| prdata | output | 32 | Read data |
| pll_ready | input | 1 | PLL lock flag from the PHY |
| ctrl_q | output | 192 | All twelve control words, word n at bits 16n+15:16n |
| lane_idle | output | 4 | Per-lane transmit idle |
| lane_pd | output | 4 | Per-lane transmit power-down |
| iddq_en | output | 1 | Quiescent-current test enable |
| pll_pd | output | 1 | PLL power-down |
| pll_fbdiv | output | 15 | PLL feedback divider |
| tx_term | output | 3 | Transmit termination trim |
| rate_sel | output | 2 | Link rate select |
| ref_div | output | 4 | Reference divider |
| ssc_depth | output | 4 | Spread-spectrum depth |
| ssc_en | output | 1 | Spread-spectrum enable |
| ssc_cnt | output | 10 | Spread-spectrum period count |
| aux_idle | output | 1 | Auxiliary channel idle |
| aux_rx_pd | output | 1 | Auxiliary receiver power-down |
| aux_tx_pd | output | 1 | Auxiliary driver power-down |
| phy_up | output | 1 | PHY already brought up (auxiliary channel not idle) |

## Verification
Read data is combinational, so the bench samples prdata one nanosecond after it drives the read request, within that same cycle. A write lands on the clock edge that closes its access cycle. The stored word and every decoded field are therefore due one cycle later, and the bench samples them at the next falling edge, after it has already dropped psel. For the ignored cases (setup cycle only, misaligned offset, status offset) the bench reads the words those writes could have hit and expects them unchanged.

// File: rtl/phycfg_pkg.sv
// Package: shared constants and reset values for the PHY configuration bank.
// Assumes 16-bit control words and a 32-bit bus whose upper half is a write mask.
package phycfg_pkg;
    localparam int unsigned CW_W     = 16;
    localparam int unsigned BUS_W    = 2 * CW_W;
    localparam int unsigned IDX_PWR  = 0;
    localparam int unsigned IDX_PLL  = 1;
    localparam int unsigned IDX_TXC  = 2;
    localparam int unsigned IDX_SSC  = 6;
    localparam int unsigned IDX_AUX  = 10;
    localparam logic [CW_W-1:0] RST_PWR = 16'h0FF1;
    localparam logic [CW_W-1:0] RST_AUX = 16'h0007;

    // Reset value of control word idx
    function automatic logic [CW_W-1:0] ctrl_reset(input int unsigned idx);
        if (idx == IDX_PWR) return RST_PWR;
        if (idx == IDX_AUX) return RST_AUX;
        return '0;
    endfunction
endpackage

// File: rtl/phycfg_addr_dec.sv
// Module: address decoder. Turns a byte offset into a one-hot control-word
// select and a status select. Assumes word-aligned offsets; others hit nothing.
module phycfg_addr_dec #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CTRL = 12
) (
    input  logic [ADDR_W-1:0]   addr,
    output logic [NUM_CTRL-1:0] ctrl_hit,
    output logic                stat_hit
);
    localparam int unsigned WORD_W = ADDR_W - 2;

    logic              aligned;
    logic [WORD_W-1:0] word;

    assign aligned = (addr[1:0] == 2'b00);
    assign word    = addr[ADDR_W-1:2];

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_hit
        assign ctrl_hit[g] = aligned && (word == WORD_W'(g));
    end

    assign stat_hit = aligned && (word == WORD_W'(NUM_CTRL));
endmodule

// File: rtl/phycfg_mask_reg.sv
// Module: one control word with a per-bit write mask. Assumes the mask and
// the data arrive together in the cycle where we is high.
module phycfg_mask_reg #(
    parameter int unsigned   W   = 16,
    parameter logic [W-1:0]  RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] wmask,
    output logic [W-1:0] q
);
    // Purpose: load the masked bits on a write and keep all the others
    always_ff @(posedge clk) begin
        if (!rst_n)  q <= RST;
        else if (we) q <= (q & ~wmask) | (wdata & wmask);
    end
endmodule

// File: rtl/phycfg_rd_mux.sv
// Module: read-data selector. Combinational; yields zero unless a read is
// requested and the offset hits a control word or the status word.
module phycfg_rd_mux #(
    parameter int unsigned NUM_CTRL = 12,
    parameter int unsigned CW_W     = 16,
    parameter int unsigned BUS_W    = 32
) (
    input  logic                     rd_en,
    input  logic [NUM_CTRL-1:0]      ctrl_hit,
    input  logic                     stat_hit,
    input  logic [NUM_CTRL*CW_W-1:0] regs,
    input  logic                     pll_ready,
    output logic [BUS_W-1:0]         rdata
);
    // Purpose: OR together the selected word, zero-extended to the bus
    always_comb begin
        rdata = '0;
        if (rd_en) begin
            for (int i = 0; i < NUM_CTRL; i++) begin
                if (ctrl_hit[i]) rdata[CW_W-1:0] = rdata[CW_W-1:0] | regs[i*CW_W +: CW_W];
            end
            if (stat_hit) rdata[0] = pll_ready;
        end
    end
endmodule

// File: rtl/phy_cfg_regbank.sv
// Module: top of the masked-write PHY configuration bank. Holds NUM_CTRL
// control words, decodes the main PHY fields and serves status reads.
// Assumes a two-phase peripheral bus with no wait states.
module phy_cfg_regbank
    import phycfg_pkg::*;
#(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CTRL = 12
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [ADDR_W-1:0]        paddr,
    input  logic [BUS_W-1:0]         pwdata,
    output logic [BUS_W-1:0]         prdata,
    input  logic                     pll_ready,
    output logic [NUM_CTRL*CW_W-1:0] ctrl_q,
    output logic [3:0]               lane_idle,
    output logic [3:0]               lane_pd,
    output logic                     iddq_en,
    output logic                     pll_pd,
    output logic [14:0]              pll_fbdiv,
    output logic [2:0]               tx_term,
    output logic [1:0]               rate_sel,
    output logic [3:0]               ref_div,
    output logic [3:0]               ssc_depth,
    output logic                     ssc_en,
    output logic [9:0]               ssc_cnt,
    output logic                     aux_idle,
    output logic                     aux_rx_pd,
    output logic                     aux_tx_pd,
    output logic                     phy_up
);
    logic                wr_acc;
    logic                rd_en;
    logic [NUM_CTRL-1:0] ctrl_hit;
    logic                stat_hit;
    logic [CW_W-1:0]     w_pwr, w_pll, w_txc, w_ssc, w_aux;

    assign wr_acc = psel && penable && pwrite;
    assign rd_en  = psel && !pwrite;

    phycfg_addr_dec #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL)) u_dec (
        .addr     (paddr),
        .ctrl_hit (ctrl_hit),
        .stat_hit (stat_hit)
    );

    for (genvar g = 0; g < NUM_CTRL; g++) begin : g_reg
        phycfg_mask_reg #(.W(CW_W), .RST(ctrl_reset(g))) u_reg (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (wr_acc && ctrl_hit[g]),
            .wdata (pwdata[CW_W-1:0]),
            .wmask (pwdata[BUS_W-1:CW_W]),
            .q     (ctrl_q[g*CW_W +: CW_W])
        );
    end

    phycfg_rd_mux #(.NUM_CTRL(NUM_CTRL), .CW_W(CW_W), .BUS_W(BUS_W)) u_rd (
        .rd_en     (rd_en),
        .ctrl_hit  (ctrl_hit),
        .stat_hit  (stat_hit),
        .regs      (ctrl_q),
        .pll_ready (pll_ready),
        .rdata     (prdata)
    );

    assign w_pwr = ctrl_q[IDX_PWR*CW_W +: CW_W];
    assign w_pll = ctrl_q[IDX_PLL*CW_W +: CW_W];
    assign w_txc = ctrl_q[IDX_TXC*CW_W +: CW_W];
    assign w_ssc = ctrl_q[IDX_SSC*CW_W +: CW_W];
    assign w_aux = ctrl_q[IDX_AUX*CW_W +: CW_W];

    assign lane_idle = w_pwr[11:8];
    assign lane_pd   = w_pwr[7:4];
    assign iddq_en   = w_pwr[1];
    assign pll_pd    = w_pwr[0];
    assign pll_fbdiv = w_pll[14:0];
    assign tx_term   = w_txc[10:8];
    assign rate_sel  = w_txc[5:4];
    assign ref_div   = w_txc[3:0];
    assign ssc_depth = w_ssc[15:12];
    assign ssc_en    = w_ssc[11];
    assign ssc_cnt   = w_ssc[9:0];
    assign aux_idle  = w_aux[2];
    assign aux_rx_pd = w_aux[1];
    assign aux_tx_pd = w_aux[0];
    assign phy_up    = ~w_aux[2];
endmodule

// File: rtl/phy_cfg_regbank_chk.sv
// Module: property checker for phy_cfg_regbank, attached by bind below.
// Observes ports only; drives nothing.
module phy_cfg_regbank_chk #(
    parameter int unsigned ADDR_W   = 8,
    parameter int unsigned NUM_CTRL = 12
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   psel,
    input logic                   penable,
    input logic                   pwrite,
    input logic [ADDR_W-1:0]      paddr,
    input logic [31:0]            pwdata,
    input logic [31:0]            prdata,
    input logic                   pll_ready,
    input logic [NUM_CTRL*16-1:0] ctrl_q,
    input logic                   pll_pd,
    input logic                   aux_idle,
    input logic                   phy_up
);
    localparam logic [ADDR_W-1:0] STAT_OFS = ADDR_W'(NUM_CTRL * 4);

    logic wr;
    assign wr = psel && penable && pwrite;

    p_keep_unmasked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == '0 && !pwdata[16]) |=> $stable(pll_pd));
    p_take_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr == '0 && pwdata[16]) |=> (pll_pd == $past(pwdata[0])));
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        prdata[31:16] == 16'h0);
    p_status_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (psel && !pwrite && paddr == STAT_OFS) |-> (prdata == {31'h0, pll_ready}));
    p_status_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr >= STAT_OFS) |=> $stable(ctrl_q));
    p_phy_up_r9: assert property (@(posedge clk) disable iff (!rst_n)
        phy_up != aux_idle);
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !wr |=> $stable(ctrl_q));
    p_misaligned_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && paddr[1:0] != 2'b00) |=> $stable(ctrl_q));
endmodule

bind phy_cfg_regbank phy_cfg_regbank_chk #(.ADDR_W(ADDR_W), .NUM_CTRL(NUM_CTRL)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .psel      (psel),
    .penable   (penable),
    .pwrite    (pwrite),
    .paddr     (paddr),
    .pwdata    (pwdata),
    .prdata    (prdata),
    .pll_ready (pll_ready),
    .ctrl_q    (ctrl_q),
    .pll_pd    (pll_pd),
    .aux_idle  (aux_idle),
    .phy_up    (phy_up)
);

// File: tb/tb_phy_cfg_regbank.sv
// Bench: a vector table of masked writes and expected readback, then
// directed checks for reset, status, decoded fields and ignored accesses.
module tb_phy_cfg_regbank;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [7:0]   paddr = '0;
    logic [31:0]  pwdata = '0;
    logic [31:0]  prdata;
    logic         pll_ready = 1'b0;
    logic [191:0] ctrl_q;
    logic [3:0]   lane_idle, lane_pd, ssc_depth, ref_div;
    logic         iddq_en, pll_pd, ssc_en, aux_idle, aux_rx_pd, aux_tx_pd, phy_up;
    logic [14:0]  pll_fbdiv;
    logic [2:0]   tx_term;
    logic [1:0]   rate_sel;
    logic [9:0]   ssc_cnt;

    int n_chk = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    phy_cfg_regbank dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pll_ready(pll_ready),
        .ctrl_q(ctrl_q), .lane_idle(lane_idle), .lane_pd(lane_pd), .iddq_en(iddq_en),
        .pll_pd(pll_pd), .pll_fbdiv(pll_fbdiv), .tx_term(tx_term), .rate_sel(rate_sel),
        .ref_div(ref_div), .ssc_depth(ssc_depth), .ssc_en(ssc_en), .ssc_cnt(ssc_cnt),
        .aux_idle(aux_idle), .aux_rx_pd(aux_rx_pd), .aux_tx_pd(aux_tx_pd), .phy_up(phy_up)
    );

    // {offset, write word, expected 16-bit readback of that offset}
    localparam int NV = 12;
    localparam logic [55:0] VEC [NV] = '{
        {8'h04, 32'hFFFF_4380, 16'h4380},
        {8'h04, 32'h00F0_FFFF, 16'h43F0},
        {8'h00, 32'h0F00_0000, 16'h00F1},
        {8'h00, 32'h0001_0000, 16'h00F0},
        {8'h08, 32'hFFFF_0110, 16'h0110},
        {8'h18, 32'hFFFF_997D, 16'h997D},
        {8'h18, 32'h0800_0000, 16'h917D},
        {8'h28, 32'h0003_0000, 16'h0004},
        {8'h2C, 32'h0000_FFFF, 16'h0000},
        {8'h30, 32'hFFFF_FFFF, 16'h0000},
        {8'h3C, 32'hFFFF_FFFF, 16'h0000},
        {8'h14, 32'hA5A5_FFFF, 16'hA5A5}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = a; pwdata = d;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; penable = 1'b0; paddr = a;
        #1 d = prdata;
        @(negedge clk);
        psel = 1'b0;
    endtask

    initial begin : main
        logic [31:0] rd;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R3: reset values
        bus_read(8'h00, rd); check("R3 word00", rd, 32'h0000_0FF1);
        bus_read(8'h28, rd); check("R3 word28", rd, 32'h0000_0007);
        bus_read(8'h04, rd); check("R3 word04", rd, 32'h0);
        check("R9 phy_up at reset", {31'h0, phy_up}, 32'h0);

        // R10: setup phase alone does nothing
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; penable = 1'b0; paddr = 8'h04; pwdata = 32'hFFFF_FFFF;
        @(negedge clk);
        psel = 1'b0; pwrite = 1'b0;
        bus_read(8'h04, rd); check("R10 setup only", rd, 32'h0);

        // R1 R2 R5 R11: table of masked writes
        for (int i = 0; i < NV; i++) begin
            bus_write(VEC[i][55:48], VEC[i][47:16]);
            bus_read(VEC[i][55:48], rd);
            check("R1/R2/R5 vector", rd, {16'h0, VEC[i][15:0]});
        end

        // R6 R7 R8 R9: decoded fields after the table
        check("R6 lane_idle", {28'h0, lane_idle}, 32'h0);
        check("R6 lane_pd", {28'h0, lane_pd}, 32'hF);
        check("R6 pll_pd/iddq", {30'h0, iddq_en, pll_pd}, 32'h0);
        check("R7 pll_fbdiv", {17'h0, pll_fbdiv}, 32'h43F0);
        check("R7 term/rate/ref", {21'h0, tx_term, rate_sel, ref_div}, {21'h0, 3'd1, 2'd1, 4'd0});
        check("R8 ssc", {15'h0, ssc_depth, ssc_en, ssc_cnt}, {15'h0, 4'h9, 1'b0, 10'h17D});
        check("R9 aux fields", {29'h0, aux_idle, aux_rx_pd, aux_tx_pd}, 32'h4);

        // R10 R9: field due in the cycle after the access edge
        bus_write(8'h28, 32'h0004_0000);
        check("R10 R9 phy_up next cycle", {31'h0, phy_up}, 32'h1);

        // R4: status word
        pll_ready = 1'b1;
        bus_read(8'h30, rd); check("R4 pll ready", rd, 32'h1);
        bus_read(8'h34, rd); check("R4 status1", rd, 32'h0);

        // R11: misaligned write and read
        bus_write(8'h05, 32'hFFFF_0000);
        bus_read(8'h04, rd); check("R11 misaligned write", rd, 32'h43F0);
        bus_read(8'h05, rd); check("R11 misaligned read", rd, 32'h0);

        // R5: status write leaves pll_ready view and words intact
        bus_write(8'h34, 32'hFFFF_FFFF);
        bus_read(8'h14, rd); check("R5 status write", rd, 32'hA5A5);
        bus_read(8'h40, rd); check("R5 unmapped read", rd, 32'h0);

        // R3: reset again restores power-down state
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R3 reset pll_pd", {31'h0, pll_pd}, 32'h1);
        bus_read(8'h18, rd); check("R3 word18 after reset", rd, 32'h0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule